// File: doc/BRIEF.md
# Multi-Port MDIO Management Master

This block is a clause-22 station-management master that serves several independent PHY management buses. Each bus has its own clock output and its own bidirectional data line, which is split into an output value, an output enable and an input. A host issues a command that names a port, an operation, a 5-bit PHY address, a 5-bit register address and 16 bits of data. The block then serialises one management frame on the chosen port only. While that happens, every other port stays idle.

The management clock comes from the system clock through a divider. It spends `HALF_DIV` system cycles low and `HALF_DIV` cycles high, so `HALF_DIV` = 25 at 125 MHz gives 2.5 MHz. The master changes its data line only on the clock's falling transition, and it samples read data on its own rising transition. The block also offers an indirect extended-register write. This command issues two write frames back to back to the same PHY. The first puts the extended address into register 0x1E and the second puts the value into register 0x1F. The host sees a single busy period and a single done pulse for the pair.

Top module: `mdio_multi_master`

## Requirements
- R1: While `rst` is high, and on the cycle after it, every `mdc` bit is 0, every `mdio_oe` bit is 0, and `busy` and `done` are 0.
- R2: Each frame is 64 management-clock periods long. Its first 32 bits are logic 1, and the start pattern 0 then 1 follows them.
- R3: After the start pattern come the opcode, the PHY address and the register address, each sent MSB first. `cmd_op` selects the operation: 2'b01 is a read and puts opcode bits 1,0 on the line. Codes 2'b00 and 2'b11 are plain writes and put opcode bits 0,1 on the line. Code 2'b10 is the indirect extended write.
- R4: In a write frame, the master drives the turnaround as 1 then 0 and sends `cmd_wdata` MSB first. It drives the output enable for all 64 bits.
- R5: In a read frame, the output enable is low for the two turnaround bits and the 16 data bits (frame bits 46 to 63). The master samples the input on each of its 16 data-bit clock rises, MSB first, and presents the word on `rd_data` together with `done`.
- R6: Within a frame, consecutive rising edges of the management clock are 2*`HALF_DIV` system cycles apart. `mdio_o` and `mdio_oe` hold steady while `mdc` is high.
- R7: Only the port named by `cmd_port` toggles its clock or enables its driver. At most one port is active at any cycle.
- R8: A command is taken only when `cmd_valid` is high and `busy` is low. `busy` rises on the next edge, and a command offered while `busy` is high produces no frame. `done` is a single-cycle pulse on the edge where `busy` falls.
- R9: Code 2'b10 sends two write frames on one port to `cmd_phy`. The first writes `cmd_ext_addr` to register 0x1E and the second writes `cmd_wdata` to register 0x1F. `busy` stays high across both frames, and one `done` follows.
- R10: When `busy` is low, every `mdc` bit is 0 and every output enable is 0, so the lines are released to their pull-ups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | 00/11 write, 01 read, 10 indirect extended write |
| cmd_port | input | PORT_W | Index of the bus to use |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address (unused by the extended write) |
| cmd_wdata | input | 16 | Write data, or the extended value |
| cmd_ext_addr | input | 16 | Extended register address for code 10 |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Data returned by the last read |
| mdc | output | NUM_PORTS | Management clock, one per port |
| mdio_o | output | NUM_PORTS | Data line output value, one per port |
| mdio_oe | output | NUM_PORTS | Data line output enable, one per port |
| mdio_i | input | NUM_PORTS | Data line input, one per port |

## Verification
The assertions check several properties on every cycle: the reset state, the rule that at most one port is active, the release of all lines whenever the block is idle, data holding steady through the clock-high phase, and the pairing of `done` with the falling edge of `busy`. The scenarios must show the rest. These are the bit-exact frame content for reads, writes and the alternate write code, the release window during a read and the sampled read word, the two-frame register order of the extended write, the clock spacing, and the fact that a command offered while busy leaves no trace on any bus.

// File: rtl/mdio_mm_pkg.sv
package mdio_mm_pkg;

  localparam int FRAME_BITS = 64;
  localparam int TA_POS     = 46;  // first turnaround bit index
  localparam int DATA_POS   = 48;  // first data bit index
  localparam logic [4:0] XREG_ADDR = 5'h1E;
  localparam logic [4:0] XREG_DATA = 5'h1F;

  typedef enum logic [1:0] {
    MM_WR     = 2'b00,
    MM_RD     = 2'b01,
    MM_XWR    = 2'b10,
    MM_WR_ALT = 2'b11
  } mm_op_e;

  // Whole frame, first bit on the wire in the MSB.
  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic        rd,
    input logic [4:0]  phy,
    input logic [4:0]  rg,
    input logic [15:0] data
  );
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
            (rd ? 2'b11 : 2'b10), data};
  endfunction

endpackage

// File: rtl/mdio_mm_pacer.sv
module mdio_mm_pacer #(
  parameter int HALF_DIV = 25,
  localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/mdio_mm_frame_engine.sv
module mdio_mm_frame_engine
  import mdio_mm_pkg::*;
#(
  parameter int HALF_DIV = 25
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic                  is_rd,
  input  logic                  line_in,
  output logic                  active,
  output logic                  clk_out,
  output logic                  line_out,
  output logic                  line_oe,
  output logic                  frame_done,
  output logic [15:0]           rd_word
);

  localparam logic [5:0] LAST_IDX = 6'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] shreg;
  logic [5:0]            idx;
  logic                  rd_r;
  logic                  tick;

  mdio_mm_pacer #(.HALF_DIV(HALF_DIV)) u_pacer (
    .clk (clk),
    .rst (rst),
    .run (active),
    .tick(tick)
  );

  assign line_out = shreg[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      clk_out    <= 1'b0;
      line_oe    <= 1'b0;
      frame_done <= 1'b0;
      shreg      <= '0;
      idx        <= '0;
      rd_r       <= 1'b0;
      rd_word    <= '0;
    end else begin
      frame_done <= 1'b0;
      if (!active) begin
        if (start) begin
          active  <= 1'b1;
          clk_out <= 1'b0;
          shreg   <= frame;
          idx     <= '0;
          rd_r    <= is_rd;
          line_oe <= 1'b1;
        end
      end else if (tick) begin
        if (!clk_out) begin
          // rising edge of the management clock: read samples here
          clk_out <= 1'b1;
          if (rd_r && idx >= 6'(DATA_POS))
            rd_word <= {rd_word[14:0], line_in};
        end else if (idx == LAST_IDX) begin
          clk_out    <= 1'b0;
          active     <= 1'b0;
          line_oe    <= 1'b0;
          frame_done <= 1'b1;
        end else begin
          // falling edge: move to the next bit while the clock is low
          clk_out <= 1'b0;
          shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
          idx     <= idx + 6'd1;
          line_oe <= !(rd_r && (idx + 6'd1) >= 6'(TA_POS));
        end
      end
    end
  end

endmodule

// File: rtl/mdio_multi_master.sv
module mdio_multi_master
  import mdio_mm_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int HALF_DIV  = 25,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic [PORT_W-1:0]    cmd_port,
  input  logic [4:0]           cmd_phy,
  input  logic [4:0]           cmd_reg,
  input  logic [15:0]          cmd_wdata,
  input  logic [15:0]          cmd_ext_addr,
  output logic                 busy,
  output logic                 done,
  output logic [15:0]          rd_data,
  output logic [NUM_PORTS-1:0] mdc,
  output logic [NUM_PORTS-1:0] mdio_o,
  output logic [NUM_PORTS-1:0] mdio_oe,
  input  logic [NUM_PORTS-1:0] mdio_i
);

  logic [PORT_W-1:0] port_q;
  logic [4:0]        phy_q, reg_q;
  logic [15:0]       data_q, pend_data_q;
  logic              rd_q, pend_q, start_q;

  logic              eng_active, eng_mdc, eng_o, eng_oe, eng_done, eng_in;
  logic [15:0]       eng_rd;
  logic [NUM_PORTS-1:0] in_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      rd_data     <= '0;
      port_q      <= '0;
      phy_q       <= '0;
      reg_q       <= '0;
      data_q      <= '0;
      pend_data_q <= '0;
      rd_q        <= 1'b0;
      pend_q      <= 1'b0;
      start_q     <= 1'b0;
    end else begin
      done    <= 1'b0;
      start_q <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          busy        <= 1'b1;
          start_q     <= 1'b1;
          port_q      <= cmd_port;
          phy_q       <= cmd_phy;
          rd_q        <= (cmd_op == MM_RD);
          pend_q      <= (cmd_op == MM_XWR);
          pend_data_q <= cmd_wdata;
          if (cmd_op == MM_XWR) begin
            reg_q  <= XREG_ADDR;
            data_q <= cmd_ext_addr;
          end else begin
            reg_q  <= cmd_reg;
            data_q <= cmd_wdata;
          end
        end
      end else if (eng_done) begin
        if (pend_q) begin
          // second frame of the extended write
          pend_q  <= 1'b0;
          reg_q   <= XREG_DATA;
          data_q  <= pend_data_q;
          start_q <= 1'b1;
        end else begin
          busy <= 1'b0;
          done <= 1'b1;
          if (rd_q) rd_data <= eng_rd;
        end
      end
    end
  end

  mdio_mm_frame_engine #(.HALF_DIV(HALF_DIV)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .start     (start_q),
    .frame     (build_frame(rd_q, phy_q, reg_q, data_q)),
    .is_rd     (rd_q),
    .line_in   (eng_in),
    .active    (eng_active),
    .clk_out   (eng_mdc),
    .line_out  (eng_o),
    .line_oe   (eng_oe),
    .frame_done(eng_done),
    .rd_word   (eng_rd)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    assign hit        = (port_q == PORT_W'(p)) && eng_active;
    assign mdc[p]     = hit && eng_mdc;
    assign mdio_o[p]  = hit && eng_o;
    assign mdio_oe[p] = hit && eng_oe;
    assign in_sel[p]  = hit && mdio_i[p];
  end

  assign eng_in = |in_sel;

endmodule

// File: rtl/mdio_mm_checker.sv
module mdio_mm_checker #(
  parameter int NUM_PORTS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 busy,
  input logic                 done,
  input logic [NUM_PORTS-1:0] mdc,
  input logic [NUM_PORTS-1:0] mdio_o,
  input logic [NUM_PORTS-1:0] mdio_oe
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (mdc == '0 && mdio_oe == '0 && !busy && !done));

  assert_one_port_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mdc | mdio_oe));

  assert_idle_release_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (mdc == '0 && mdio_oe == '0));

  assert_hold_high_R6: assert property (@(posedge clk) disable iff (rst)
    ((|mdc) && $past(|mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  assert_done_edge_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

bind mdio_multi_master mdio_mm_checker #(.NUM_PORTS(NUM_PORTS)) i_mm_checker (
  .clk    (clk),
  .rst    (rst),
  .busy   (busy),
  .done   (done),
  .mdc    (mdc),
  .mdio_o (mdio_o),
  .mdio_oe(mdio_oe)
);

// File: tb/test_mdio_multi_master.sv
module test_mdio_multi_master;

  localparam int NP = 4;
  localparam int HD = 4;
  localparam int PW = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          rst;
  logic          cmd_valid;
  logic [1:0]    cmd_op;
  logic [PW-1:0] cmd_port;
  logic [4:0]    cmd_phy, cmd_reg;
  logic [15:0]   cmd_wdata, cmd_ext_addr;
  logic          busy, done;
  logic [15:0]   rd_data;
  logic [NP-1:0] mdc, mdio_o, mdio_oe, mdio_i;

  mdio_multi_master #(.NUM_PORTS(NP), .HALF_DIV(HD)) i_mdio_multi_master (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_port(cmd_port), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
    .cmd_wdata(cmd_wdata), .cmd_ext_addr(cmd_ext_addr), .busy(busy),
    .done(done), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  typedef struct { int port; logic [63:0] bits; logic [63:0] oem; } frame_t;
  typedef struct { bit rd; logic [15:0] val; } resp_t;

  frame_t exp_q[$];
  resp_t  rsp_q[$];
  int n_chk = 0, n_fail = 0;
  logic [15:0] phy_val = 16'h0;
  bit stray = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected wire content; released bits read as 1 through the pull-up.
  task automatic push_frame(input int port, input bit rd, input logic [4:0] phy,
                            input logic [4:0] rg, input logic [15:0] data);
    frame_t f;
    f.port = port;
    f.bits = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, data};
    f.oem  = '1;
    if (rd) begin
      f.bits[17:0] = '1;
      f.oem[17:0]  = '0;
    end
    exp_q.push_back(f);
  endtask

  task automatic issue(input int port, input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] rg, input logic [15:0] wd,
                       input logic [15:0] xa, input logic [15:0] rv);
    resp_t r;
    if (op == 2'b10) begin
      push_frame(port, 0, phy, 5'h1E, xa);
      push_frame(port, 0, phy, 5'h1F, wd);
    end else begin
      push_frame(port, op == 2'b01, phy, rg, wd);
    end
    r.rd = (op == 2'b01); r.val = rv;
    rsp_q.push_back(r);
    phy_val = rv;
    @(negedge clk);
    while (busy) @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_port = PW'(port); cmd_phy = phy;
    cmd_reg = rg; cmd_wdata = wd; cmd_ext_addr = xa;
    @(negedge clk);
    cmd_valid = 0;
    check(busy == 1'b1, "R8 busy after accept", 64'(busy), 64'd1);
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: decode frames on every port, model the PHY, check responses.
  logic [63:0] fb [NP];
  logic [63:0] om [NP];
  int          rc [NP];
  int          last_rise [NP];
  logic [NP-1:0] prev_mdc;

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      prev_mdc = '0;
      mdio_i   = '1;
      for (int p = 0; p < NP; p++) begin rc[p] = 0; fb[p] = '0; om[p] = '0; last_rise[p] = 0; end
    end else begin
      if ($countones(mdc | mdio_oe) > 1) stray = 1;
      for (int p = 0; p < NP; p++) begin
        if (mdc[p] && !prev_mdc[p]) begin
          fb[p] = {fb[p][62:0], (mdio_oe[p] ? mdio_o[p] : 1'b1)};
          om[p] = {om[p][62:0], mdio_oe[p]};
          rc[p]++;
          if (rc[p] > 1)
            check(cyc - last_rise[p] == 2 * HD, "R6 mdc period",
                  64'(cyc - last_rise[p]), 64'(2 * HD));
          last_rise[p] = cyc;
          if (rc[p] >= 48 && rc[p] <= 63) mdio_i[p] = phy_val[63 - rc[p]];
          else mdio_i[p] = 1'b1;
          if (rc[p] == 64) begin
            if (exp_q.size() == 0) begin
              check(0, "R8 unexpected frame", fb[p], 64'd0);
            end else begin
              frame_t e;
              e = exp_q.pop_front();
              check(e.port == p, "R7 frame port", 64'(p), 64'(e.port));
              check(fb[p] == e.bits, "R2 R3 R4 R9 frame bits", fb[p], e.bits);
              check(om[p] == e.oem, "R4 R5 enable mask", om[p], e.oem);
            end
            rc[p] = 0;
          end
        end
      end
      prev_mdc = mdc;
      if (done) begin
        check(!stray, "R7 single active port", 64'(stray), 64'd0);
        stray = 0;
        check(mdc == '0 && mdio_oe == '0, "R10 released at done",
              {mdc, mdio_oe}, 64'd0);
        if (rsp_q.size() == 0) begin
          check(0, "R8 extra done", 64'd1, 64'd0);
        end else begin
          resp_t r;
          r = rsp_q.pop_front();
          if (r.rd) check(rd_data == r.val, "R5 read data", 64'(rd_data), 64'(r.val));
        end
      end
    end
  end

  bit finished = 0;

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    rst = 1; cmd_valid = 0; cmd_op = 0; cmd_port = 0; cmd_phy = 0;
    cmd_reg = 0; cmd_wdata = 0; cmd_ext_addr = 0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(mdc == '0 && mdio_oe == '0 && !busy && !done, "R1 reset state",
          {mdc, mdio_oe, 6'(busy), 6'(done)}, 64'd0);

    issue(0, 2'b00, 5'h01, 5'h03, 16'hA5C3, 16'h0, 16'h0);  wait_done();   // R4
    issue(1, 2'b01, 5'h1F, 5'h00, 16'h0, 16'h0, 16'h011A);  wait_done();   // R5 R3
    issue(3, 2'b01, 5'h00, 5'h1F, 16'h0, 16'h0, 16'h8001);  wait_done();   // R5
    issue(2, 2'b10, 5'h05, 5'h00, 16'h0604, 16'hA00D, 16'h0); wait_done(); // R9
    issue(1, 2'b00, 5'h00, 5'h00, 16'h0000, 16'h0, 16'h0);  wait_done();   // R2
    issue(3, 2'b11, 5'h1F, 5'h1F, 16'hFFFF, 16'h0, 16'h0);  wait_done();   // R3 alt write
    issue(0, 2'b01, 5'h0A, 5'h15, 16'h0, 16'h0, 16'hFFFF);  wait_done();   // R5
    issue(2, 2'b01, 5'h15, 5'h0A, 16'h0, 16'h0, 16'h0000);  wait_done();   // R5

    // R8: a command offered while busy must leave no frame anywhere
    issue(2, 2'b00, 5'h02, 5'h04, 16'h1234, 16'h0, 16'h0);
    repeat (100) @(negedge clk);
    cmd_valid = 1; cmd_op = 2'b01; cmd_port = 2'd3; cmd_phy = 5'h07; cmd_reg = 5'h01;
    @(negedge clk);
    cmd_valid = 0;
    wait_done();
    repeat (4 * 64 * HD) @(negedge clk);
    check(exp_q.size() == 0 && rsp_q.size() == 0, "R8 queues drained",
          64'(exp_q.size() + rsp_q.size()), 64'd0);
    check(!busy && mdc == '0 && mdio_oe == '0, "R10 idle after ignored cmd",
          {mdc, mdio_oe, 7'(busy)}, 64'd0);

    finished = 1;
    summary();
  end

endmodule